// File: doc/BRIEF.md
# Dual Reference Clock Selection Controller

This block picks which of two reference clock inputs feeds the downstream clock multiplier. It also drives three status pins whose roles depend on configuration. Each input comes with an alarm flag from an external detector, which covers loss of signal and, where the detector is set up for it, frequency offset. The block brings these alarm flags into its own clock domain. It then chooses the active input in one of two ways. In manual mode the choice comes from an external select pin or from a register bit. In automatic mode the block fails over to the clean input when the active one raises an alarm. When both inputs are in alarm, the block freezes its choice on the input last used and raises a hold flag.

The three status pins are each driven with a separate output enable, so each one can be tristated. The first pin is either a maskable interrupt or the alarm indicator for input 1. The second pin is the alarm indicator for input 2. The third pin is the manual select input; in automatic mode it can instead report the active input. Software reaches the configuration, the interrupt mask and flags, and a read-only status word through a small parallel register port. An active-low reset restores every register to zero and keeps the clock output enable low for as long as reset is held.

Top module: `clksel_ctrl`

## Requirements
- R1: In manual mode (config bit 0 = 0) with pin select disabled (config bit 1 = 0), config bit 2 chooses the active input (0 gives act_idx_o = 0 for input 1, 1 gives input 2), and the select pin stays tristated (csel_oe_o = 0).
- R2: In manual mode with config bit 1 = 1, act_idx_o follows sel_pin_i (0 selects input 1, 1 selects input 2), and config bit 2 has no effect.
- R3: In automatic mode (config bit 0 = 1) with config bit 3 = 1, csel_oe_o = 1 and csel_o equals act_idx_o. With config bit 3 = 0, or in manual mode, csel_oe_o = 0.
- R4: In automatic mode, input 1 is active after reset. When the active input is in alarm and the other input is clean, the selection moves to the other input. This happens on the third clock edge after the raw alarm changes: two edges for synchronization and one for the selection register. The selection never moves back by itself.
- R5: While both synchronized alarms are high, hold_o = 1 and act_idx_o keeps the input last used. As soon as either input leaves alarm, hold_o clears and the selection settles on a clean input.
- R6: Register address 2 is read-only status. Bit 0 gives the active input and bit 1 gives the hold flag, whatever the pin enable settings are.
- R7: With config bit 4 = 1, the first pin is driven (int_c1_oe_o = 1) and shows the interrupt as int_c1_o = irq XOR config bit 5. Polarity 0 is active high.
- R8: With config bit 4 = 0 and config bit 6 = 1, the first pin shows the synchronized input-1 alarm XOR config bit 8 (1 means alarm when bit 8 = 0). With both bit 4 and bit 6 at 0, int_c1_oe_o = 0.
- R9: With config bit 7 = 1, the second pin shows the synchronized input-2 alarm XOR config bit 8 (c2_oe_o = 1). Otherwise c2_oe_o = 0.
- R10: Register address 1 holds the interrupt mask in bits 1:0 and the sticky flags in bits 3:2. A flag is set while its synchronized alarm is high. It clears only when a 1 is written to its bit position, and setting wins over clearing. The interrupt is the OR of each flag ANDed with its mask bit.
- R11: Asserting rst_n low at once clears clkout_oe_o and keeps it low. Every register reads back zero after reset, and clkout_oe_o rises on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm1_i | input | 1 | Raw alarm for input 1 (asynchronous) |
| alarm2_i | input | 1 | Raw alarm for input 2 (asynchronous) |
| sel_pin_i | input | 1 | External manual select level (asynchronous) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address for reads and writes |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i |
| act_idx_o | output | 1 | Active input index (0 = input 1, 1 = input 2) |
| hold_o | output | 1 | Hold state, both inputs in alarm |
| clkout_oe_o | output | 1 | Clock output enable, low during reset |
| int_c1_o | output | 1 | Interrupt or input-1 alarm pin level |
| int_c1_oe_o | output | 1 | Drive enable for int_c1_o |
| c2_o | output | 1 | Input-2 alarm pin level |
| c2_oe_o | output | 1 | Drive enable for c2_o |
| csel_o | output | 1 | Active-input indicator level |
| csel_oe_o | output | 1 | Drive enable for csel_o |

## Verification
The failover and hold assertions treat the synchronized alarms as the truth for each input, so they only describe the block once the raw alarms have passed through both synchronizer stages. The sticky-flag properties assume that a register write and a rising alarm can coincide, and they check that setting wins in that case. The stimulus changes raw alarms, the select pin and register writes only on falling clock edges. It holds each alarm pattern for several cycles before it samples pin roles, so that every expected value is taken from settled synchronizer state. The one exception is the latency check, which counts edges exactly.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    // Configuration word; bit 0 is the last member.
    typedef struct packed {
        logic bad_pol;     // bit 8: alarm pin polarity (0 = high on alarm)
        logic c2_bad_pin;  // bit 7: second pin shows input-2 alarm
        logic c1_bad_pin;  // bit 6: first pin shows input-1 alarm
        logic int_pol;     // bit 5: interrupt polarity (0 = active high)
        logic int_pin;     // bit 4: first pin is the interrupt
        logic act_pin_en;  // bit 3: select pin reports active input (auto)
        logic sel_reg;     // bit 2: register choice in manual mode
        logic sel_pin_en;  // bit 1: manual choice taken from the pin
        logic auto_mode;   // bit 0: automatic selection
    } cfg_t;

    localparam int CFG_W     = $bits(cfg_t);
    localparam int ADDR_CFG  = 0;
    localparam int ADDR_IRQ  = 1;
    localparam int ADDR_STAT = 2;
    localparam int NUM_IN    = 2;

endpackage

// File: rtl/clksel_sync.sv
module clksel_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/clksel_regs.sv
module clksel_regs
    import clksel_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NUM_IN-1:0] alarm_s_i,
    input  logic              act_i,
    input  logic              hold_i,
    output cfg_t              cfg_o,
    output logic              irq_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        cfg_t              cfg;
        logic [NUM_IN-1:0] mask;
        logic [NUM_IN-1:0] flag;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic wr_cfg, wr_irq;
    logic unused_wdata;

    assign wr_cfg = we_i && (addr_i == ADDR_W'(ADDR_CFG));
    assign wr_irq = we_i && (addr_i == ADDR_W'(ADDR_IRQ));
    assign unused_wdata = ^wdata_i;

    always_comb begin
        st_d = st_q;
        if (wr_cfg) begin
            st_d.cfg = cfg_t'(wdata_i[CFG_W-1:0]);
        end
        if (wr_irq) begin
            st_d.mask = wdata_i[NUM_IN-1:0];
            st_d.flag = st_q.flag & ~wdata_i[2*NUM_IN-1:NUM_IN];
        end
        st_d.flag = st_d.flag | alarm_s_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(ADDR_CFG):  rdata_o = DATA_W'(st_q.cfg);
            ADDR_W'(ADDR_IRQ):  rdata_o = DATA_W'({st_q.flag, st_q.mask});
            ADDR_W'(ADDR_STAT): rdata_o = DATA_W'({alarm_s_i, hold_i, act_i});
            default:            rdata_o = '0;
        endcase
    end

    assign cfg_o = st_q.cfg;
    assign irq_o = |(st_q.flag & st_q.mask);

    // R10: a flag stays set unless a clear write hit its bit.
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.flag[0]) && !($past(wr_irq) && $past(wdata_i[NUM_IN])))
        |-> st_q.flag[0]);

    // R10: an alarm seen in one cycle leaves its flag set in the next.
    a_r10_flag_on_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_s_i[1] |=> st_q.flag[1]);

endmodule

// File: rtl/clksel_arb.sv
module clksel_arb
    import clksel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_i,
    input  logic              sel_pin_en_i,
    input  logic              sel_reg_i,
    input  logic              sel_pin_s_i,
    input  logic [NUM_IN-1:0] alarm_s_i,
    output logic              act_o,
    output logic              hold_o
);

    typedef struct packed {
        logic act;
        logic hold;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic cur_bad, alt_bad;

    assign cur_bad = alarm_s_i[st_q.act];
    assign alt_bad = alarm_s_i[~st_q.act];

    always_comb begin
        st_d      = st_q;
        st_d.hold = &alarm_s_i;
        if (auto_i) begin
            if (cur_bad && !alt_bad) begin
                st_d.act = ~st_q.act;
            end
        end else begin
            st_d.act = sel_pin_en_i ? sel_pin_s_i : sel_reg_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o  = st_q.act;
    assign hold_o = st_q.hold;

    // R4: a failing active input with a clean alternative forces a move.
    a_r4_failover: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_i && cur_bad && !alt_bad) |=> (act_o != $past(act_o)));

    // R5: the hold flag only follows a cycle in which both alarms were high.
    a_r5_hold_both_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> $past(alarm_s_i == 2'b11));

    // R5: while holding in automatic mode the selection is frozen.
    a_r5_hold_keeps_act: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_i && hold_o) |=> (!auto_i || !hold_o || $stable(act_o)));

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm1_i,
    input  logic              alarm2_i,
    input  logic              sel_pin_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              act_idx_o,
    output logic              hold_o,
    output logic              clkout_oe_o,
    output logic              int_c1_o,
    output logic              int_c1_oe_o,
    output logic              c2_o,
    output logic              c2_oe_o,
    output logic              csel_o,
    output logic              csel_oe_o
);

    localparam int SYNC_W = NUM_IN + 1;

    logic [SYNC_W-1:0] raw_in, sync_out;
    logic [NUM_IN-1:0] alarm_s;
    logic              sel_pin_s;
    cfg_t              cfg;
    logic              irq;
    logic              oe_d, oe_q;

    assign raw_in    = {sel_pin_i, alarm2_i, alarm1_i};
    assign alarm_s   = sync_out[NUM_IN-1:0];
    assign sel_pin_s = sync_out[NUM_IN];

    clksel_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (SYNC_W)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_out)
    );

    clksel_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (reg_we_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .alarm_s_i (alarm_s),
        .act_i     (act_idx_o),
        .hold_i    (hold_o),
        .cfg_o     (cfg),
        .irq_o     (irq),
        .rdata_o   (reg_rdata_o)
    );

    clksel_arb arb_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .auto_i       (cfg.auto_mode),
        .sel_pin_en_i (cfg.sel_pin_en),
        .sel_reg_i    (cfg.sel_reg),
        .sel_pin_s_i  (sel_pin_s),
        .alarm_s_i    (alarm_s),
        .act_o        (act_idx_o),
        .hold_o       (hold_o)
    );

    // Clock output enable: low throughout reset.
    always_comb begin
        oe_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= oe_d;
        end
    end

    assign clkout_oe_o = oe_q;

    // Pin role multiplexing.
    always_comb begin
        int_c1_oe_o = 1'b0;
        int_c1_o    = 1'b0;
        if (cfg.int_pin) begin
            int_c1_oe_o = 1'b1;
            int_c1_o    = irq ^ cfg.int_pol;
        end else if (cfg.c1_bad_pin) begin
            int_c1_oe_o = 1'b1;
            int_c1_o    = alarm_s[0] ^ cfg.bad_pol;
        end
    end

    assign c2_oe_o   = cfg.c2_bad_pin;
    assign c2_o      = cfg.c2_bad_pin & (alarm_s[1] ^ cfg.bad_pol);
    assign csel_oe_o = cfg.auto_mode & cfg.act_pin_en;
    assign csel_o    = csel_oe_o & act_idx_o;

    // R11: clock outputs stay disabled while reset is held.
    a_r11_clkout_off: assert property (@(posedge clk)
        !rst_n |-> !clkout_oe_o);

endmodule

// File: tb/clksel_ctrl_tb_top.sv
module clksel_ctrl_tb_top;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alarm1_i = 1'b0, alarm2_i = 1'b0, sel_pin_i = 1'b0;
    logic              reg_we_i = 1'b0;
    logic [ADDR_W-1:0] reg_addr_i = '0;
    logic [DATA_W-1:0] reg_wdata_i = '0;
    logic [DATA_W-1:0] reg_rdata_o;
    logic act_idx_o, hold_o, clkout_oe_o;
    logic int_c1_o, int_c1_oe_o, c2_o, c2_oe_o, csel_o, csel_oe_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    clksel_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .alarm1_i(alarm1_i), .alarm2_i(alarm2_i),
        .sel_pin_i(sel_pin_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .act_idx_o(act_idx_o), .hold_o(hold_o), .clkout_oe_o(clkout_oe_o),
        .int_c1_o(int_c1_o), .int_c1_oe_o(int_c1_oe_o), .c2_o(c2_o),
        .c2_oe_o(c2_oe_o), .csel_o(csel_o), .csel_oe_o(csel_oe_o)
    );

    task automatic check(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        reg_we_i    = 1'b1;
        reg_addr_i  = ADDR_W'(addr);
        reg_wdata_i = DATA_W'(data);
        @(negedge clk);
        reg_we_i    = 1'b0;
    endtask

    task automatic rd(input int addr, output int data);
        reg_addr_i = ADDR_W'(addr);
        #1;
        data = int'(reg_rdata_o);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int pin(input logic oe, input logic v);
        return oe ? (2 + int'(v)) : 0;
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            report();
        end
    end

    initial begin
        int rv;
        int act_m;
        int a1, a2, irq;
        int combos [4];
        combos = '{0, 1, 3, 2};   // {a2,a1}: clean, in1 bad, both, in2 bad

        // R11: reset state
        cycles(3);
        check("R11 clkout_oe in reset", int'(clkout_oe_o), 0);
        check("R11 pins tristated in reset",
              int'({int_c1_oe_o, c2_oe_o, csel_oe_o}), 0);
        check("R4 act input1 after reset", int'(act_idx_o), 0);
        check("R5 hold clear after reset", int'(hold_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 clkout_oe after release", int'(clkout_oe_o), 1);
        rd(0, rv);
        check("R11 config default", rv, 0);
        rd(1, rv);
        check("R11 irq reg default", rv, 0);

        // Sweep pin roles in automatic mode over four alarm patterns.
        act_m = 0;
        wr(0, 1);
        foreach (combos[k]) begin
            a1 = combos[k] & 1;
            a2 = (combos[k] >> 1) & 1;
            @(negedge clk);
            alarm1_i = a1[0];
            alarm2_i = a2[0];
            cycles(6);
            if (((a1 == 1 && act_m == 0) && a2 == 0) ||
                ((a2 == 1 && act_m == 1) && a1 == 0)) act_m = 1 - act_m;
            check("R4 auto selection", int'(act_idx_o), act_m);
            check("R5 hold flag", int'(hold_o), a1 & a2);
            wr(1, 32'h0000_000D);       // mask=01, clear both flags
            rd(1, rv);
            check("R10 flags follow alarms", (rv >> 2) & 3, (a2 << 1) | a1);
            irq = a1;
            for (int r = 0; r < 64; r++) begin
                int cfgw;
                int e_c1, e_c2, e_cs;
                cfgw = 1 | ((r & 1) << 3) | (((r >> 1) & 15) << 4) | (((r >> 5) & 1) << 8);
                wr(0, cfgw);
                if ((r >> 1) & 1) e_c1 = 2 + (irq ^ ((r >> 2) & 1));
                else if ((r >> 3) & 1) e_c1 = 2 + (a1 ^ ((r >> 5) & 1));
                else e_c1 = 0;
                e_c2 = ((r >> 4) & 1) ? 2 + (a2 ^ ((r >> 5) & 1)) : 0;
                e_cs = (r & 1) ? 2 + act_m : 0;
                check($sformatf("R7 R8 first pin cfg=%0h", cfgw),
                      pin(int_c1_oe_o, int_c1_o), e_c1);
                check($sformatf("R9 second pin cfg=%0h", cfgw),
                      pin(c2_oe_o, c2_o), e_c2);
                check($sformatf("R3 indicator pin cfg=%0h", cfgw),
                      pin(csel_oe_o, csel_o), e_cs);
            end
        end
        @(negedge clk);
        alarm1_i = 1'b0;
        alarm2_i = 1'b0;
        cycles(6);

        // R1: manual register choice
        wr(0, 4);
        cycles(2);
        check("R1 manual reg selects input2", int'(act_idx_o), 1);
        check("R1 select pin tristated", int'(csel_oe_o), 0);
        rd(2, rv);
        check("R6 status shows act with pins off", rv & 1, 1);
        wr(0, 0);
        cycles(2);
        check("R1 manual reg selects input1", int'(act_idx_o), 0);

        // R2: manual pin choice, register bit ignored
        wr(0, 2 | 4);
        @(negedge clk);
        sel_pin_i = 1'b0;
        cycles(5);
        check("R2 pin 0 overrides reg bit", int'(act_idx_o), 0);
        sel_pin_i = 1'b1;
        cycles(5);
        check("R2 pin 1 selects input2", int'(act_idx_o), 1);
        check("R3 manual mode pin tristated", int'(csel_oe_o), 0);
        sel_pin_i = 1'b0;
        wr(0, 0);
        cycles(3);

        // R4: failover latency and no revert
        wr(0, 1);
        cycles(2);
        alarm1_i = 1'b1;
        cycles(2);
        check("R4 no switch before 3rd edge", int'(act_idx_o), 0);
        cycles(1);
        check("R4 switch on 3rd edge", int'(act_idx_o), 1);
        alarm1_i = 1'b0;
        cycles(6);
        check("R4 no revert to input1", int'(act_idx_o), 1);

        // R5: hold on both alarms, resume on a clean input
        alarm1_i = 1'b1;
        alarm2_i = 1'b1;
        cycles(6);
        check("R5 hold set", int'(hold_o), 1);
        check("R5 last input kept", int'(act_idx_o), 1);
        rd(2, rv);
        check("R6 status hold bit", (rv >> 1) & 1, 1);
        alarm1_i = 1'b0;
        cycles(6);
        check("R5 hold cleared", int'(hold_o), 0);
        check("R5 resume on clean input1", int'(act_idx_o), 0);
        alarm2_i = 1'b0;
        cycles(6);

        // R10/R7: sticky flags and interrupt pin
        wr(1, 32'h0000_000C);           // mask=00, clear flags
        rd(1, rv);
        check("R10 flags cleared", (rv >> 2) & 3, 0);
        alarm2_i = 1'b1;
        @(negedge clk);
        alarm2_i = 1'b0;
        cycles(8);
        rd(1, rv);
        check("R10 flag2 sticky after pulse", (rv >> 2) & 3, 2);
        check("R4 inactive-input alarm no switch", int'(act_idx_o), 0);
        wr(0, 1 | 16);
        check("R10 masked flag no irq", pin(int_c1_oe_o, int_c1_o), 2);
        wr(1, 2);
        check("R7 irq active high", pin(int_c1_oe_o, int_c1_o), 3);
        wr(0, 1 | 16 | 32);
        check("R7 irq inverted polarity", pin(int_c1_oe_o, int_c1_o), 2);
        wr(1, 2 | 8);
        check("R10 clear drops irq", pin(int_c1_oe_o, int_c1_o), 3);

        // R11: reset in the middle of operation
        wr(0, 9'h1FF);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11 clkout_oe drops at once", int'(clkout_oe_o), 0);
        cycles(2);
        check("R11 clkout_oe held low", int'(clkout_oe_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(0, rv);
        check("R11 config back to default", rv, 0);
        check("R11 clkout_oe back on", int'(clkout_oe_o), 1);

        done = 1;
        report();
    end

endmodule